// File: doc/BRIEF.md
# Multi-Source XOR and Zero-Check Engine

This block is the data engine that sits behind one DMA channel and executes a single decoded descriptor. The controller presents an operation control word, a byte-count word and a fill constant with a one-cycle start handshake. The engine then produces a destination stream of 32-bit words on a valid/ready port. Each word is either a copy of one source, the XOR of up to sixteen sources, or the fill constant.

In zero-check mode no destination data leaves the engine. The XOR of all sources is folded across the whole transfer into one error flag. When the transfer finishes, the engine returns the byte-count word with its status bits rewritten. It marks completion with a one-cycle done pulse. A descriptor with a zero byte count moves no data and only produces the done pulse, which the controller uses to raise an interrupt.

Sources arrive on sixteen independent valid/ready ports. For each word offset the engine takes one word from every active source in ascending index order, and it takes one word per cycle. It then emits or checks the accumulated word before it moves to the next offset.

Top module: `xor_zero_engine`

## Requirements
- R1: The active source count is control bits 6:3 plus one. For each word offset the engine accepts exactly one word from each of sources 0 to count-1, in ascending index order, and it never asserts more than one source ready at a time.
- R2: With block fill and zero check both clear, each destination word is the XOR of the words taken from the active sources at that offset. With one source, this makes the operation a plain copy.
- R3: When control bit 8 is set, every destination word equals the fill constant and no source word is accepted. This mode takes precedence over control bit 7.
- R4: The number of destination words is the byte count (bits 23:0 of the byte-count word) divided by four and rounded up. On the final word, byte-enable bit i covers data bits 8i+7:8i, and only the lowest (count mod 4) bytes are enabled when that remainder is nonzero. Every other word has all four enables set, and dstLast is high only on the final word.
- R5: When control bit 7 is set and bit 8 is clear, the engine produces no destination word. The error flag is set if any enabled byte of any accumulated XOR word is nonzero. Bytes that the final word's byte enable excludes are ignored.
- R6: The returned status word carries bits 28:0 of the input byte-count word unchanged and has bit 29 at 0. Bit 31 equals control bit 12, and bit 30 is the zero-check error flag ANDed with control bit 12.
- R7: doneValid is high for exactly one cycle. That cycle is the one after the final destination word is accepted, or, in zero-check mode, the one after the final source word is accepted.
- R8: When the byte count is zero, doneValid rises the cycle after the start is accepted, and no source or destination transfer takes place.
- R9: startReady is high only while the engine is idle. A destination word that is offered and not accepted keeps its data, byte enables and last flag unchanged until it is accepted.
- R10: After reset the engine is idle: busy, doneValid, dstValid and all source readies are low and startReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Descriptor present |
| startReady | output | 1 | Engine idle, descriptor accepted |
| ctrlWord | input | 32 | Operation control word |
| byteCount | input | 32 | Byte-count word |
| fillWord | input | 32 | Fill constant |
| srcValid | input | MAX_SRC | Per-source word valid |
| srcReady | output | MAX_SRC | Per-source word accept |
| srcData | input | 32*MAX_SRC | Source words, source i in bits 32i+31:32i |
| dstValid | output | 1 | Destination word valid |
| dstReady | input | 1 | Destination word accepted |
| dstData | output | 32 | Destination word |
| dstBe | output | 4 | Destination byte enables |
| dstLast | output | 1 | Final destination word |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCount | output | 32 | Updated byte-count status word |
| busy | output | 1 | Descriptor in progress |

## Verification
On every cycle, the assertions check several properties that hold regardless of the data. They check that at most one source ready is high, that a fill descriptor never reads a source and that a zero-check descriptor never offers output. They also check that a stalled output word holds still, that the Q flag stays clear in the status word and that the done pulse lasts one cycle. The values themselves can only be shown by the bench's scenarios, which compare against a queue-based model while the source and sink stall at random. These values are the XOR words, the tail byte enables, the zero-check verdict when the garbage lies outside the tail mask, the status word for each mode, and the exact done cycle for normal, zero-check and zero-length descriptors.

// File: rtl/xze_pkg.sv
package xze_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EMIT,
    ST_DONE
  } engState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;      // capture descriptor fields
    logic accEn;     // a source word is accepted this cycle
    logic accFirst;  // that word is from source 0 (restart accumulator)
    logic zeroFold;  // fold the finished XOR word into the zero flag
    logic lastWord;  // current offset is the final word
  } engStrobe_t;

endpackage

// File: rtl/xze_ctrl.sv
module xze_ctrl
  import xze_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = 24,
  localparam int IDX_W   = $clog2(MAX_SRC),
  localparam int WORDS_W = CNT_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  output logic               startReady,
  input  logic               fillEn,
  input  logic               zeroEn,
  input  logic [IDX_W-1:0]   srcLastIn,
  input  logic [CNT_W-1:0]   byteLen,
  input  logic [MAX_SRC-1:0] srcValid,
  output logic [MAX_SRC-1:0] srcReady,
  output logic               dstValid,
  input  logic               dstReady,
  output logic               dstLast,
  output logic               doneValid,
  output logic               busy,
  output logic [IDX_W-1:0]   srcSel,
  output engStrobe_t         strobe
);

  engState_t          state;
  logic               modeFill;
  logic               modeZero;
  logic [IDX_W-1:0]   srcLastIdx;
  logic [IDX_W-1:0]   srcIdx;
  logic [WORDS_W-1:0] wordsLeft;

  logic [CNT_W:0]     roundedLen;
  logic [WORDS_W-1:0] numWords;
  logic               lastWord;
  logic               srcFire;
  logic               lastSrc;
  logic               startFire;

  // words = ceil(bytes / 4)
  assign roundedLen = {1'b0, byteLen} + (CNT_W+1)'(3);
  assign numWords   = roundedLen[CNT_W:2];

  assign lastWord  = (wordsLeft == WORDS_W'(1));
  assign lastSrc   = (srcIdx == srcLastIdx);
  assign startReady = (state == ST_IDLE);
  assign startFire = startValid && startReady;
  assign srcFire   = (state == ST_READ) && srcValid[srcIdx];
  assign dstValid  = (state == ST_EMIT);
  assign dstLast   = dstValid && lastWord;
  assign doneValid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign srcSel    = srcIdx;

  always_comb begin
    for (int i = 0; i < MAX_SRC; i++) begin
      srcReady[i] = (state == ST_READ) && (srcIdx == IDX_W'(i));
    end
  end

  always_comb begin
    strobe.load     = startFire;
    strobe.accEn    = srcFire;
    strobe.accFirst = (srcIdx == '0);
    strobe.zeroFold = srcFire && lastSrc && modeZero;
    strobe.lastWord = lastWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeFill   <= 1'b0;
      modeZero   <= 1'b0;
      srcLastIdx <= '0;
      srcIdx     <= '0;
      wordsLeft  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startFire) begin
            modeFill   <= fillEn;
            modeZero   <= zeroEn && !fillEn;
            srcLastIdx <= srcLastIn;
            srcIdx     <= '0;
            wordsLeft  <= numWords;
            if (numWords == '0)  state <= ST_DONE;
            else if (fillEn)     state <= ST_EMIT;
            else                 state <= ST_READ;
          end
        end
        ST_READ: begin
          if (srcFire) begin
            if (lastSrc) begin
              srcIdx <= '0;
              if (modeZero) begin
                wordsLeft <= wordsLeft - WORDS_W'(1);
                state     <= lastWord ? ST_DONE : ST_READ;
              end else begin
                state <= ST_EMIT;
              end
            end else begin
              srcIdx <= srcIdx + IDX_W'(1);
            end
          end
        end
        ST_EMIT: begin
          if (dstReady) begin
            wordsLeft <= wordsLeft - WORDS_W'(1);
            if (lastWord)      state <= ST_DONE;
            else if (modeFill) state <= ST_EMIT;
            else               state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xze_datapath.sv
module xze_datapath
  import xze_pkg::*;
#(
  parameter int MAX_SRC = 16,
  localparam int IDX_W  = $clog2(MAX_SRC),
  localparam int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  engStrobe_t                strobe,
  input  logic [IDX_W-1:0]          srcSel,
  input  logic [WORD_W*MAX_SRC-1:0] srcData,
  input  logic                      fillEn,
  input  logic                      wbEnIn,
  input  logic [28:0]               countLow,
  input  logic [WORD_W-1:0]         fillWord,
  output logic [WORD_W-1:0]         dstData,
  output logic [3:0]                dstBe,
  output logic [31:0]               doneCount
);

  logic [WORD_W-1:0] srcWords [MAX_SRC];
  logic [WORD_W-1:0] fillReg;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] accNext;
  logic [WORD_W-1:0] byteMask;
  logic [28:0]       cntReg;
  logic              isFill;
  logic              wbEn;
  logic              zeroErr;
  logic [3:0]        tailBe;

  for (genvar s = 0; s < MAX_SRC; s++) begin : g_split
    assign srcWords[s] = srcData[s*WORD_W +: WORD_W];
  end

  assign accNext = (strobe.accFirst ? '0 : acc) ^ srcWords[srcSel];

  // Tail mask: lowest (count mod 4) bytes, or all four when aligned.
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      tailBe[b] = (cntReg[1:0] == 2'd0) || (2'(b) < cntReg[1:0]);
    end
  end

  assign dstBe = strobe.lastWord ? tailBe : 4'hF;

  for (genvar b = 0; b < 4; b++) begin : g_mask
    assign byteMask[8*b +: 8] = {8{dstBe[b]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillReg <= '0;
      acc     <= '0;
      cntReg  <= '0;
      isFill  <= 1'b0;
      wbEn    <= 1'b0;
      zeroErr <= 1'b0;
    end else begin
      if (strobe.load) begin
        fillReg <= fillWord;
        cntReg  <= countLow;
        isFill  <= fillEn;
        wbEn    <= wbEnIn;
        zeroErr <= 1'b0;
      end
      if (strobe.accEn) acc <= accNext;
      if (strobe.zeroFold && |(accNext & byteMask)) zeroErr <= 1'b1;
    end
  end

  assign dstData   = isFill ? fillReg : acc;
  assign doneCount = {wbEn, wbEn & zeroErr, 1'b0, cntReg};

endmodule

// File: rtl/xor_zero_engine.sv
module xor_zero_engine
  import xze_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int CNT_W   = 24,
  localparam int IDX_W  = $clog2(MAX_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  output logic                  startReady,
  input  logic [31:0]           ctrlWord,
  input  logic [31:0]           byteCount,
  input  logic [31:0]           fillWord,
  input  logic [MAX_SRC-1:0]    srcValid,
  output logic [MAX_SRC-1:0]    srcReady,
  input  logic [32*MAX_SRC-1:0] srcData,
  output logic                  dstValid,
  input  logic                  dstReady,
  output logic [31:0]           dstData,
  output logic [3:0]            dstBe,
  output logic                  dstLast,
  output logic                  doneValid,
  output logic [31:0]           doneCount,
  output logic                  busy
);

  engStrobe_t       strobe;
  logic [IDX_W-1:0] srcSel;
  logic             unusedBits;

  assign unusedBits = ^{ctrlWord[31:13], ctrlWord[11:9], ctrlWord[2:0],
                        byteCount[31:29]};

  xze_ctrl #(.MAX_SRC(MAX_SRC), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startReady (startReady),
    .fillEn     (ctrlWord[8]),
    .zeroEn     (ctrlWord[7]),
    .srcLastIn  (ctrlWord[3 +: IDX_W]),
    .byteLen    (byteCount[CNT_W-1:0]),
    .srcValid   (srcValid),
    .srcReady   (srcReady),
    .dstValid   (dstValid),
    .dstReady   (dstReady),
    .dstLast    (dstLast),
    .doneValid  (doneValid),
    .busy       (busy),
    .srcSel     (srcSel),
    .strobe     (strobe)
  );

  xze_datapath #(.MAX_SRC(MAX_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcSel    (srcSel),
    .srcData   (srcData),
    .fillEn    (ctrlWord[8]),
    .wbEnIn    (ctrlWord[12]),
    .countLow  (byteCount[28:0]),
    .fillWord  (fillWord),
    .dstData   (dstData),
    .dstBe     (dstBe),
    .doneCount (doneCount)
  );

endmodule

// File: rtl/xor_zero_engine_chk.sv
module xor_zero_engine_chk #(
  parameter int MAX_SRC = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               startFire,
  input logic               fillBit,
  input logic               zeroBit,
  input logic [MAX_SRC-1:0] srcReady,
  input logic               dstValid,
  input logic               dstReady,
  input logic [31:0]        dstData,
  input logic [3:0]         dstBe,
  input logic               dstLast,
  input logic               doneValid,
  input logic               doneQFlag,
  input logic               busy
);

  logic modeFill;
  logic modeZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFill <= 1'b0;
      modeZero <= 1'b0;
    end else if (startFire) begin
      modeFill <= fillBit;
      modeZero <= zeroBit;
    end
  end

  assert_one_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReady));

  assert_fill_no_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && modeFill |-> srcReady == '0);

  assert_zero_no_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy && modeZero && !modeFill |-> !dstValid);

  assert_q_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !doneQFlag);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_dst_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    dstValid && !dstReady |=> dstValid && $stable(dstData) && $stable(dstBe) && $stable(dstLast));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> srcReady == '0 && !dstValid && !doneValid);

endmodule

bind xor_zero_engine xor_zero_engine_chk #(.MAX_SRC(MAX_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startFire (startValid && startReady),
  .fillBit   (ctrlWord[8]),
  .zeroBit   (ctrlWord[7]),
  .srcReady  (srcReady),
  .dstValid  (dstValid),
  .dstReady  (dstReady),
  .dstData   (dstData),
  .dstBe     (dstBe),
  .dstLast   (dstLast),
  .doneValid (doneValid),
  .doneQFlag (doneCount[29]),
  .busy      (busy)
);

// File: tb/xor_zero_engine_bench.sv
`timescale 1ns/1ps
module xor_zero_engine_bench;

  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic          startReady;
  logic [31:0]   ctrlWord = '0;
  logic [31:0]   byteCount = '0;
  logic [31:0]   fillWord = '0;
  logic [NS-1:0] srcValid = '0;
  logic [NS-1:0] srcReady;
  logic [32*NS-1:0] srcData = '0;
  logic          dstValid;
  logic          dstReady = 1'b0;
  logic [31:0]   dstData;
  logic [3:0]    dstBe;
  logic          dstLast;
  logic          doneValid;
  logic [31:0]   doneCount;
  logic          busy;

  always #4 clk = ~clk;  // 125 MHz

  xor_zero_engine u_xor_zero_engine (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .ctrlWord(ctrlWord), .byteCount(byteCount), .fillWord(fillWord),
    .srcValid(srcValid), .srcReady(srcReady), .srcData(srcData),
    .dstValid(dstValid), .dstReady(dstReady), .dstData(dstData), .dstBe(dstBe),
    .dstLast(dstLast), .doneValid(doneValid), .doneCount(doneCount), .busy(busy)
  );

  // Reference model state
  logic [31:0] srcQ [NS][$];
  int          orderQ[$];
  logic [31:0] expData[$];
  logic [3:0]  expBe[$];
  bit          expLast[$];
  logic [31:0] expDone;
  int          remainFinal = 0;
  bit          finalOnSrc = 0;
  int          cycle = 0;
  int          finalCycle = -100;
  int          pendSrc = -1;
  bit          doneSeen = 0;
  bit          stallOn = 0;
  logic [15:0] lfsr = 16'hACE1;
  string       doneTag = "R7";
  string       orderTag = "R1";
  int          errors = 0;
  int          checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle driver and comparator
  always @(negedge clk) begin
    if (rstN) begin
      cycle++;
      if (pendSrc >= 0) begin
        void'(srcQ[pendSrc].pop_front());
        pendSrc = -1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < NS; i++) begin
        srcValid[i] = (srcQ[i].size() > 0) && (!stallOn || lfsr[i]);
        srcData[i*32 +: 32] = (srcQ[i].size() > 0) ? srcQ[i][0] : 32'h0;
      end
      dstReady = !stallOn || (lfsr[3] ^ lfsr[7]);
      #1;
      if (busy) check(!startReady, "R9", "startReady while busy", {31'b0, startReady}, 32'h0);
      if (doneValid || cycle == finalCycle + 1) begin
        check(doneValid && cycle == finalCycle + 1, doneTag, "done timing",
              {31'b0, doneValid}, 32'h1);
        if (doneValid) begin
          check(doneCount == expDone, "R6", "status word", doneCount, expDone);
          doneSeen = 1;
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (srcValid[i] && srcReady[i]) begin
          check(orderQ.size() > 0 && orderQ[0] == i, orderTag, "source order",
                i, (orderQ.size() > 0) ? orderQ[0] : -1);
          if (orderQ.size() > 0) void'(orderQ.pop_front());
          pendSrc = i;
          if (finalOnSrc && remainFinal > 0) begin
            remainFinal--;
            if (remainFinal == 0) finalCycle = cycle;
          end
        end
      end
      if (dstValid) begin
        check(expData.size() > 0, "R5", "unexpected output word", dstData, 32'h0);
        if (dstReady && expData.size() > 0) begin
          check(dstData == expData[0], "R2", "output data", dstData, expData[0]);
          check(dstBe == expBe[0], "R4", "byte enable", {28'b0, dstBe}, {28'b0, expBe[0]});
          check(dstLast == expLast[0], "R4", "last flag", {31'b0, dstLast}, {31'b0, expLast[0]});
          void'(expData.pop_front());
          void'(expBe.pop_front());
          void'(expLast.pop_front());
          if (!finalOnSrc && remainFinal > 0) begin
            remainFinal--;
            if (remainFinal == 0) finalCycle = cycle;
          end
        end
      end
      if (startValid && startReady && remainFinal == 0) finalCycle = cycle;
    end
  end

  // pattern: 0 random, 1 XOR zero everywhere, 2 zero except bytes outside tail mask
  task automatic runDesc(input logic [31:0] ctrl, input logic [31:0] cnt,
                         input logic [31:0] fill, input int pattern,
                         input string dTag, input string oTag);
    int nsrc;
    int nw;
    int tail;
    bit fillM;
    bit zeroM;
    bit zerr;
    logic [31:0] x;
    logic [31:0] d;
    logic [31:0] m;
    logic [3:0] be;
    @(negedge clk);
    #3;
    nsrc  = int'(ctrl[6:3]) + 1;
    nw    = (int'(cnt[23:0]) + 3) / 4;
    tail  = int'(cnt[1:0]);
    fillM = ctrl[8];
    zeroM = ctrl[7] && !ctrl[8];
    zerr  = 0;
    for (int i = 0; i < NS; i++) srcQ[i].delete();
    orderQ.delete();
    expData.delete();
    expBe.delete();
    expLast.delete();
    for (int w = 0; w < nw; w++) begin
      be = (w == nw - 1 && tail != 0) ? 4'((1 << tail) - 1) : 4'hF;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      x = '0;
      for (int s = 0; s < nsrc; s++) begin
        d = $urandom;
        if (s == nsrc - 1 && pattern == 1) d = x;
        if (s == nsrc - 1 && pattern == 2) d = x ^ ~m;
        if (fillM) srcQ[s].push_back(d);  // offered but must stay untouched
        else begin
          srcQ[s].push_back(d);
          orderQ.push_back(s);
        end
        x = x ^ d;
      end
      if (fillM) begin
        expData.push_back(fill);
        expBe.push_back(be);
        expLast.push_back(w == nw - 1);
      end else if (zeroM) begin
        if ((x & m) != 0) zerr = 1;
      end else begin
        expData.push_back(x);
        expBe.push_back(be);
        expLast.push_back(w == nw - 1);
      end
    end
    expDone     = {ctrl[12], ctrl[12] & zerr, 1'b0, cnt[28:0]};
    finalOnSrc  = zeroM;
    remainFinal = (nw == 0) ? 0 : (zeroM ? nw * nsrc : nw);
    doneTag     = dTag;
    orderTag    = oTag;
    doneSeen    = 0;
    @(negedge clk);
    startValid = 1'b1;
    ctrlWord   = ctrl;
    byteCount  = cnt;
    fillWord   = fill;
    @(negedge clk);
    startValid = 1'b0;
    for (int t = 0; t < 5000 && !doneSeen; t++) @(negedge clk);
    check(doneSeen, dTag, "completion seen", {31'b0, doneSeen}, 32'h1);
    @(negedge clk);
    #2;
    check(orderQ.size() == 0, oTag, "sources left unread", orderQ.size(), 0);
    check(expData.size() == 0, "R4", "output words missing", expData.size(), 0);
  endtask

  function automatic logic [31:0] mkCtrl(input int nsrc, input bit zero,
                                         input bit fill, input bit wb);
    logic [31:0] c;
    c = '0;
    c[6:3] = 4'(nsrc - 1);
    c[7]   = zero;
    c[8]   = fill;
    c[12]  = wb;
    c[2:1] = 2'b11;
    return c;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && startReady && srcReady == '0 && !dstValid && !doneValid, "R10",
          "reset state", {busy, startReady, dstValid, doneValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check(!busy && startReady && srcReady == '0 && !dstValid && !doneValid, "R10",
          "idle after reset", {busy, startReady, dstValid, doneValid}, 32'h4);

    stallOn = 0;
    runDesc(mkCtrl(1, 0, 0, 1), 32'd16, 32'h0, 0, "R7", "R1");           // copy, R2
    stallOn = 1;
    runDesc(mkCtrl(3, 0, 0, 0), 32'd22, 32'h0, 0, "R7", "R1");           // XOR, tail 2 bytes, R4
    runDesc(mkCtrl(16, 0, 0, 1), 32'd8, 32'h0, 0, "R7", "R1");           // all sixteen, R1
    runDesc(mkCtrl(4, 0, 1, 1), 32'd13, 32'hA5C3_0F1E, 0, "R7", "R3");   // fill, R3
    runDesc(mkCtrl(2, 1, 1, 1), 32'd9, 32'h1234_5678, 0, "R7", "R3");    // fill wins over zero, R3
    runDesc(mkCtrl(4, 1, 0, 1), 32'd32, 32'h0, 1, "R7", "R1");           // clean zero check, R5
    runDesc(mkCtrl(5, 1, 0, 1), 32'd20, 32'h0, 0, "R7", "R1");           // dirty zero check, R5
    runDesc(mkCtrl(2, 1, 0, 1), 32'd10, 32'h0, 2, "R7", "R1");           // masked garbage, R5
    runDesc(mkCtrl(3, 1, 0, 0), 32'd12, 32'h0, 0, "R7", "R1");           // no write-back, R6
    runDesc(mkCtrl(1, 0, 0, 1), 32'h3F00_0000, 32'h0, 0, "R8", "R8");    // zero length, R8
    stallOn = 0;
    runDesc(mkCtrl(2, 0, 0, 1), 32'd4, 32'h0, 0, "R7", "R1");            // single full word
    runDesc(mkCtrl(7, 1, 0, 1), 32'd3, 32'h0, 2, "R7", "R1");            // one partial word, R5

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule